// File: doc/BRIEF.md
# Processor Status and Mode Controller

This block holds the live status word of a 32-bit RISC core and the five banked copies of that word that privileged exception modes keep. The live word carries four condition flags, an IRQ mask, an FIQ mask and a five-bit mode field. Each privileged exception mode has its own banked copy. The core updates the flags after ALU operations. It moves whole status words to and from general registers with explicit transfer requests. It enters exception modes by naming the exception kind, and it returns from a handler with a restore request that reloads the live word from the bank of the current mode.

A two-bit configuration selects how wide the program and data address spaces are. When the program space is narrow, only the four legacy modes (User, FIQ, IRQ, Supervisor) are used, in their 26-bit encodings. When the data space is narrow, data addresses that fall outside the low 64 MiB raise an address exception. The unused configuration code is handled as fully narrow operation and is reported on an error output.

Top module: `psr_mode_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a rising edge), the flags are 0, both masks are 1, and the mode is Supervisor. It is 5'b10011 when prog32 and data32 are both 1, and 5'b00011 otherwise. Every banked copy is 0.
- R2: With rd_spsr low, rd_data returns the live word: flags N,Z,C,V in bits [31:28], I in bit 7, F in bit 6, mode in bits [4:0], and all other bits 0. An ALU flag write loads flags[3:0] into bits [31:28] at the next edge.
- R3: In a privileged mode, a transfer into the live word writes the flags, both masks and the mode from wdata, using the layout of R2. If the mode value is not legal for the current program width, the mode is kept. Legal 32-bit modes are 10000, 10001, 10010, 10011, 10111 and 11011. Legal 26-bit modes are 00000 to 00011.
- R4: In User mode (mode[3:0] = 0000), a transfer into the live word changes only the flags.
- R5: In User mode, reading a banked copy returns 0, and writing one has no effect.
- R6: Exception entry copies the live word into the bank of the target mode. It sets the mode and sets I. It sets F only for FIQ. xcp_kind codes are 0 = FIQ, 1 = IRQ, 2 = Supervisor, 3 = Abort, and 4 to 7 = Undefined. 32-bit targets are 10001, 10010, 10011, 10111 and 11011. Banks are shared by the 26-bit and 32-bit forms of the same mode.
- R7: With a narrow program space, exception entry uses the 26-bit codes 00001, 00010 and 00011. Abort and Undefined requests enter Supervisor (00011).
- R8: A restore request in a privileged mode reloads the live word from the bank of the current mode. The mode is checked for legality as in R3. In User mode a restore request is ignored.
- R9: addr_exc is 1 exactly when dacc_valid is 1, data32 is 0, and any of dacc_addr[31:26] is 1.
- R10: The configuration prog32=1, data32=0 raises cfg_err and behaves as prog32=0, data32=0.
- R11: In a single cycle, exception entry takes priority over restore. Restore takes priority over a transfer. A transfer into the live word takes priority over an ALU flag write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_prog32 | input | 1 | Program space width select |
| cfg_data32 | input | 1 | Data space width select |
| alu_flag_we | input | 1 | ALU flag write enable |
| alu_flags | input | 4 | New N,Z,C,V |
| xcp_req | input | 1 | Exception entry request |
| xcp_kind | input | 3 | Exception kind code |
| rest_req | input | 1 | Restore live word from current bank |
| msr_we | input | 1 | Status transfer write |
| msr_spsr | input | 1 | Transfer targets the banked copy |
| msr_wdata | input | 32 | Transfer write data |
| rd_spsr | input | 1 | Read the banked copy instead of the live word |
| rd_data | output | 32 | Status read data |
| dacc_valid | input | 1 | Data access present |
| dacc_addr | input | 32 | Data access address |
| addr_exc | output | 1 | Address exception for the data access |
| flags | output | 4 | Current N,Z,C,V |
| irq_mask | output | 1 | IRQ disable |
| fiq_mask | output | 1 | FIQ disable |
| mode | output | 5 | Current mode |
| cfg_err | output | 1 | Unused configuration code selected |

## Verification
The hardest state to reach is a banked copy that holds a nested context: an FIQ taken inside an IRQ handler that was itself entered from User mode. Two restores must then unwind it in order. The bench reaches this state by walking the core from Supervisor to User with a transfer, raising IRQ and then FIQ, and reading each bank back through rd_spsr between the restores. It also switches the configuration at run time, so that narrow-space entries and mode legality are tested from a live privileged state rather than only from reset.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int NUM_SPSR   = 5;
    localparam int SPSR_IDX_W = $clog2(NUM_SPSR);

    localparam logic [4:0] M_USR26 = 5'b00000;
    localparam logic [4:0] M_FIQ26 = 5'b00001;
    localparam logic [4:0] M_IRQ26 = 5'b00010;
    localparam logic [4:0] M_SVC26 = 5'b00011;
    localparam logic [4:0] M_USR32 = 5'b10000;
    localparam logic [4:0] M_FIQ32 = 5'b10001;
    localparam logic [4:0] M_IRQ32 = 5'b10010;
    localparam logic [4:0] M_SVC32 = 5'b10011;
    localparam logic [4:0] M_ABT32 = 5'b10111;
    localparam logic [4:0] M_UND32 = 5'b11011;

    typedef struct packed {
        logic [3:0] flags;
        logic       irq_m;
        logic       fiq_m;
        logic [4:0] mode;
    } psr_t;

    typedef struct packed {
        logic                  valid;
        logic [SPSR_IDX_W-1:0] idx;
    } slot_t;

    function automatic logic [31:0] psr_pack(psr_t p);
        return {p.flags, 20'd0, p.irq_m, p.fiq_m, 1'b0, p.mode};
    endfunction

    function automatic psr_t psr_unpack(logic [31:0] w);
        psr_t p;
        p.flags = w[31:28];
        p.irq_m = w[7];
        p.fiq_m = w[6];
        p.mode  = w[4:0];
        return p;
    endfunction

    function automatic slot_t bank_slot(logic [4:0] m);
        slot_t s;
        s.valid = 1'b1;
        s.idx   = '0;
        case (m)
            M_FIQ26, M_FIQ32: s.idx = SPSR_IDX_W'(0);
            M_IRQ26, M_IRQ32: s.idx = SPSR_IDX_W'(1);
            M_SVC26, M_SVC32: s.idx = SPSR_IDX_W'(2);
            M_ABT32:          s.idx = SPSR_IDX_W'(3);
            M_UND32:          s.idx = SPSR_IDX_W'(4);
            default:          s.valid = 1'b0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/psr_target_map.sv
module psr_target_map
    import psr_pkg::*;
(
    input  logic [2:0] kind,
    input  logic       wide_prog,
    output logic [4:0] tgt_mode,
    output logic       tgt_fiq
);
    always_comb begin
        tgt_fiq = (kind == 3'd0);
        case (kind)
            3'd0:    tgt_mode = wide_prog ? M_FIQ32 : M_FIQ26;
            3'd1:    tgt_mode = wide_prog ? M_IRQ32 : M_IRQ26;
            3'd2:    tgt_mode = wide_prog ? M_SVC32 : M_SVC26;
            3'd3:    tgt_mode = wide_prog ? M_ABT32 : M_SVC26;
            default: tgt_mode = wide_prog ? M_UND32 : M_SVC26;
        endcase
    end
endmodule

// File: rtl/psr_mode_legal.sv
module psr_mode_legal
    import psr_pkg::*;
(
    input  logic [4:0] mode_in,
    input  logic       wide_prog,
    output logic       ok
);
    always_comb begin
        if (wide_prog) begin
            case (mode_in)
                M_USR32, M_FIQ32, M_IRQ32, M_SVC32, M_ABT32, M_UND32: ok = 1'b1;
                default: ok = 1'b0;
            endcase
        end else begin
            case (mode_in)
                M_USR26, M_FIQ26, M_IRQ26, M_SVC26: ok = 1'b1;
                default: ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/psr_addr_guard.sv
module psr_addr_guard #(
    parameter int ADDR_W   = 32,
    parameter int NARROW_W = 26
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide_data,
    output logic              exc
);
    localparam int HI_W = ADDR_W - NARROW_W;
    logic [HI_W-1:0] hi_bits;

    assign hi_bits = addr[ADDR_W-1:NARROW_W];
    assign exc     = valid && !wide_data && (|hi_bits);
endmodule

// File: rtl/psr_mode_ctrl.sv
module psr_mode_ctrl
    import psr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NARROW_W = 26,
    parameter int WORD_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_prog32,
    input  logic              cfg_data32,
    input  logic              alu_flag_we,
    input  logic [3:0]        alu_flags,
    input  logic              xcp_req,
    input  logic [2:0]        xcp_kind,
    input  logic              rest_req,
    input  logic              msr_we,
    input  logic              msr_spsr,
    input  logic [WORD_W-1:0] msr_wdata,
    input  logic              rd_spsr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              dacc_valid,
    input  logic [ADDR_W-1:0] dacc_addr,
    output logic              addr_exc,
    output logic [3:0]        flags,
    output logic              irq_mask,
    output logic              fiq_mask,
    output logic [4:0]        mode,
    output logic              cfg_err
);
    localparam int NUM_CHK = 2;
    localparam int CHK_MSR = 0;
    localparam int CHK_RST = 1;

    typedef struct packed {
        psr_t                cpsr;
        psr_t [NUM_SPSR-1:0] spsr;
    } state_t;

    state_t state_d, state_q;

    logic       wide_prog, wide_data;
    logic [4:0] tgt_mode;
    logic       tgt_fiq;
    slot_t      cur_slot, tgt_slot;
    psr_t       msr_word, rest_word;
    logic [4:0] chk_mode [NUM_CHK];
    logic       chk_ok   [NUM_CHK];

    // Unused code 10 collapses onto fully narrow operation.
    assign wide_prog = cfg_prog32 && cfg_data32;
    assign wide_data = cfg_data32;
    assign cfg_err   = cfg_prog32 && !cfg_data32;

    assign cur_slot  = bank_slot(state_q.cpsr.mode);
    assign tgt_slot  = bank_slot(tgt_mode);
    assign msr_word  = psr_unpack(msr_wdata);
    assign rest_word = state_q.spsr[cur_slot.idx];

    assign chk_mode[CHK_MSR] = msr_word.mode;
    assign chk_mode[CHK_RST] = rest_word.mode;

    psr_target_map u_map (
        .kind      (xcp_kind),
        .wide_prog (wide_prog),
        .tgt_mode  (tgt_mode),
        .tgt_fiq   (tgt_fiq)
    );

    for (genvar g = 0; g < NUM_CHK; g++) begin : g_legal
        psr_mode_legal u_legal (
            .mode_in   (chk_mode[g]),
            .wide_prog (wide_prog),
            .ok        (chk_ok[g])
        );
    end

    psr_addr_guard #(
        .ADDR_W   (ADDR_W),
        .NARROW_W (NARROW_W)
    ) u_guard (
        .valid     (dacc_valid),
        .addr      (dacc_addr),
        .wide_data (wide_data),
        .exc       (addr_exc)
    );

    always_comb begin
        state_d = state_q;
        if (xcp_req) begin
            if (tgt_slot.valid) begin
                state_d.spsr[tgt_slot.idx] = state_q.cpsr;
            end
            state_d.cpsr.mode  = tgt_mode;
            state_d.cpsr.irq_m = 1'b1;
            if (tgt_fiq) begin
                state_d.cpsr.fiq_m = 1'b1;
            end
        end else if (rest_req && cur_slot.valid) begin
            state_d.cpsr.flags = rest_word.flags;
            state_d.cpsr.irq_m = rest_word.irq_m;
            state_d.cpsr.fiq_m = rest_word.fiq_m;
            if (chk_ok[CHK_RST]) begin
                state_d.cpsr.mode = rest_word.mode;
            end
        end else if (rest_req) begin
            state_d = state_q;
        end else begin
            if (msr_we && msr_spsr && cur_slot.valid) begin
                state_d.spsr[cur_slot.idx] = msr_word;
            end
            if (msr_we && !msr_spsr) begin
                state_d.cpsr.flags = msr_word.flags;
                if (cur_slot.valid) begin
                    state_d.cpsr.irq_m = msr_word.irq_m;
                    state_d.cpsr.fiq_m = msr_word.fiq_m;
                    if (chk_ok[CHK_MSR]) begin
                        state_d.cpsr.mode = msr_word.mode;
                    end
                end
            end else if (alu_flag_we) begin
                state_d.cpsr.flags = alu_flags;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q            <= '0;
            state_q.cpsr.irq_m <= 1'b1;
            state_q.cpsr.fiq_m <= 1'b1;
            state_q.cpsr.mode  <= wide_prog ? M_SVC32 : M_SVC26;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        if (!rd_spsr) begin
            rd_data = psr_pack(state_q.cpsr);
        end else if (cur_slot.valid) begin
            rd_data = psr_pack(state_q.spsr[cur_slot.idx]);
        end else begin
            rd_data = '0;
        end
    end

    assign flags    = state_q.cpsr.flags;
    assign irq_mask = state_q.cpsr.irq_m;
    assign fiq_mask = state_q.cpsr.fiq_m;
    assign mode     = state_q.cpsr.mode;
endmodule

// File: rtl/psr_mode_ctrl_chk.sv
module psr_mode_ctrl_chk #(
    parameter int ADDR_W   = 32,
    parameter int NARROW_W = 26,
    parameter int WORD_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_prog32,
    input logic              cfg_data32,
    input logic              xcp_req,
    input logic [2:0]        xcp_kind,
    input logic              rest_req,
    input logic              msr_we,
    input logic              msr_spsr,
    input logic              rd_spsr,
    input logic              dacc_valid,
    input logic [ADDR_W-1:0] dacc_addr,
    input logic [WORD_W-1:0] rd_data,
    input logic [4:0]        mode,
    input logic              irq_mask,
    input logic              fiq_mask,
    input logic              addr_exc,
    input logic              cfg_err
);
    assert_xcp_irq_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xcp_req |=> irq_mask);

    assert_xcp_fiq_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xcp_req && xcp_kind == 3'd0) |=> fiq_mask);

    assert_user_mode_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[3:0] == 4'd0 && msr_we && !msr_spsr && !xcp_req && !rest_req)
        |=> mode == $past(mode));

    assert_user_bank_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[3:0] == 4'd0 && rd_spsr) |-> rd_data == '0);

    assert_narrow_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xcp_req && !(cfg_prog32 && cfg_data32)) |=> !mode[4]);

    assert_wide_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_data32 |-> !addr_exc);

    assert_undef_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && dacc_valid && (|dacc_addr[ADDR_W-1:NARROW_W])) |-> addr_exc);
endmodule

bind psr_mode_ctrl psr_mode_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .NARROW_W (NARROW_W),
    .WORD_W   (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_prog32 (cfg_prog32),
    .cfg_data32 (cfg_data32),
    .xcp_req    (xcp_req),
    .xcp_kind   (xcp_kind),
    .rest_req   (rest_req),
    .msr_we     (msr_we),
    .msr_spsr   (msr_spsr),
    .rd_spsr    (rd_spsr),
    .dacc_valid (dacc_valid),
    .dacc_addr  (dacc_addr),
    .rd_data    (rd_data),
    .mode       (mode),
    .irq_mask   (irq_mask),
    .fiq_mask   (fiq_mask),
    .addr_exc   (addr_exc),
    .cfg_err    (cfg_err)
);

// File: tb/psr_mode_ctrl_tb.sv
module psr_mode_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_prog32 = 1'b1, cfg_data32 = 1'b1;
    logic        alu_flag_we = 1'b0;
    logic [3:0]  alu_flags = '0;
    logic        xcp_req = 1'b0;
    logic [2:0]  xcp_kind = '0;
    logic        rest_req = 1'b0;
    logic        msr_we = 1'b0, msr_spsr = 1'b0;
    logic [31:0] msr_wdata = '0;
    logic        rd_spsr = 1'b0;
    logic [31:0] rd_data;
    logic        dacc_valid = 1'b0;
    logic [31:0] dacc_addr = '0;
    logic        addr_exc;
    logic [3:0]  flags;
    logic        irq_mask, fiq_mask;
    logic [4:0]  mode;
    logic        cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    psr_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_prog32(cfg_prog32), .cfg_data32(cfg_data32),
        .alu_flag_we(alu_flag_we), .alu_flags(alu_flags),
        .xcp_req(xcp_req), .xcp_kind(xcp_kind), .rest_req(rest_req),
        .msr_we(msr_we), .msr_spsr(msr_spsr), .msr_wdata(msr_wdata),
        .rd_spsr(rd_spsr), .rd_data(rd_data),
        .dacc_valid(dacc_valid), .dacc_addr(dacc_addr), .addr_exc(addr_exc),
        .flags(flags), .irq_mask(irq_mask), .fiq_mask(fiq_mask),
        .mode(mode), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_ctl();
        alu_flag_we = 1'b0; xcp_req = 1'b0; rest_req = 1'b0;
        msr_we = 1'b0; msr_spsr = 1'b0; rd_spsr = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        clear_ctl();
        #1;
    endtask

    task automatic read_bank(output logic [31:0] v);
        rd_spsr = 1'b1; #1; v = rd_data; rd_spsr = 1'b0; #1;
    endtask

    task automatic t_reset();
        check("R1 live word", rd_data, 32'h0000_00D3);
        check("R1 masks", {30'd0, irq_mask, fiq_mask}, 32'd3);
        check("R1 mode", {27'd0, mode}, 32'h13);
    endtask

    task automatic t_alu();
        alu_flag_we = 1'b1; alu_flags = 4'b1010; tick();
        check("R2 alu flags", rd_data, 32'hA000_00D3);
        check("R2 flags port", {28'd0, flags}, 32'hA);
    endtask

    task automatic t_msr_priv();
        msr_we = 1'b1; msr_wdata = 32'h5000_0010; tick();
        check("R3 privileged transfer", rd_data, 32'h5000_0010);
    endtask

    task automatic t_user();
        logic [31:0] v;
        msr_we = 1'b1; msr_wdata = 32'hF000_00D3; tick();
        check("R4 user transfer flags only", rd_data, 32'hF000_0010);
        read_bank(v);
        check("R5 user bank read", v, 32'h0);
        msr_we = 1'b1; msr_spsr = 1'b1; msr_wdata = 32'h1234_5678; tick();
        read_bank(v);
        check("R5 user bank write ignored", v, 32'h0);
        check("R5 live word untouched", rd_data, 32'hF000_0010);
    endtask

    task automatic t_nested();
        logic [31:0] v;
        xcp_req = 1'b1; xcp_kind = 3'd1; tick();
        check("R6 irq entry", rd_data, 32'hF000_0092);
        read_bank(v);
        check("R6 irq bank", v, 32'hF000_0010);
        xcp_req = 1'b1; xcp_kind = 3'd0; tick();
        check("R6 fiq entry", rd_data, 32'hF000_00D1);
        read_bank(v);
        check("R6 fiq bank", v, 32'hF000_0092);
        rest_req = 1'b1; tick();
        check("R8 restore to irq", rd_data, 32'hF000_0092);
        read_bank(v);
        check("R8 irq bank kept", v, 32'hF000_0010);
        rest_req = 1'b1; tick();
        check("R8 restore to user", rd_data, 32'hF000_0010);
        rest_req = 1'b1; tick();
        check("R8 user restore ignored", rd_data, 32'hF000_0010);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        msr_we = 1'b1; msr_wdata = 32'h3000_0010;
        alu_flag_we = 1'b1; alu_flags = 4'b1100; tick();
        check("R11 transfer over alu", rd_data, 32'h3000_0010);
        xcp_req = 1'b1; xcp_kind = 3'd2;
        msr_we = 1'b1; msr_wdata = 32'h0000_0010; tick();
        check("R11 entry over transfer", rd_data, 32'h3000_0093);
        read_bank(v);
        check("R11 svc bank", v, 32'h3000_0010);
        msr_we = 1'b1; msr_wdata = 32'h0000_001F; tick();
        check("R3 illegal mode kept", rd_data, 32'h0000_0013);
    endtask

    task automatic t_narrow();
        logic [31:0] v;
        cfg_prog32 = 1'b0; cfg_data32 = 1'b0; #1;
        xcp_req = 1'b1; xcp_kind = 3'd3; tick();
        check("R7 abort to svc26", rd_data, 32'h0000_0083);
        read_bank(v);
        check("R7 svc bank", v, 32'h0000_0013);
        msr_we = 1'b1; msr_wdata = 32'h0000_0097; tick();
        check("R7 abt32 illegal in narrow", rd_data, 32'h0000_0083);
        msr_we = 1'b1; msr_wdata = 32'h0000_0000; tick();
        check("R7 user26", rd_data, 32'h0000_0000);
        xcp_req = 1'b1; xcp_kind = 3'd1; tick();
        check("R7 irq26 entry", rd_data, 32'h0000_0082);
    endtask

    task automatic t_addr();
        dacc_valid = 1'b1; dacc_addr = 32'h0400_0000; #1;
        check("R9 narrow high addr", {31'd0, addr_exc}, 32'd1);
        dacc_addr = 32'h03FF_FFFC; #1;
        check("R9 narrow low addr", {31'd0, addr_exc}, 32'd0);
        dacc_addr = 32'h8000_0000; dacc_valid = 1'b0; #1;
        check("R9 no access", {31'd0, addr_exc}, 32'd0);
        dacc_valid = 1'b1; cfg_data32 = 1'b1; #1;
        check("R9 wide data", {31'd0, addr_exc}, 32'd0);
        cfg_prog32 = 1'b1; #1;
        check("R9 full wide", {31'd0, addr_exc}, 32'd0);
        dacc_valid = 1'b0; #1;
    endtask

    task automatic t_undef_cfg();
        cfg_prog32 = 1'b1; cfg_data32 = 1'b0; #1;
        check("R10 error flag", {31'd0, cfg_err}, 32'd1);
        dacc_valid = 1'b1; dacc_addr = 32'h0400_0000; #1;
        check("R10 narrow data", {31'd0, addr_exc}, 32'd1);
        dacc_valid = 1'b0;
        xcp_req = 1'b1; xcp_kind = 3'd4; tick();
        check("R10 undef to svc26", {27'd0, mode}, 32'h03);
        cfg_data32 = 1'b1; #1;
        check("R10 error clears", {31'd0, cfg_err}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1; #1;
        t_reset();
        t_alu();
        t_msr_priv();
        t_user();
        t_nested();
        t_priority();
        t_narrow();
        t_addr();
        t_undef_cfg();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule